// File: doc/BRIEF.md
# Two-Wire Scan-Format Adapter

This block sits on the target side of a star-connected, reduced-pin test port. The host reaches every target over only two wires: a clock that the host alone drives (`tckc`) and one bidirectional data line. The adapter splits the time-multiplexed data line into the four conventional scan signals (clock, mode select, data in, data out). These go to an unchanged legacy test-access core behind it.

Every core clock is carried as a frame of three consecutive line slots. In the first slot the host sends the data-in bit inverted. In the second it sends the mode-select bit. In the third the host lets go of the line and the target drives the core's data-out bit onto it. The adapter holds a 4-bit controller ID. It only drives the line when the selection logic around it names that ID. The line itself is modelled as an input, an output value and an output enable, which feed an external tristate pad.

A separate escape detector can pull `esc_hold`. This forces the adapter back to the start of a frame, just as reset does, and the held controller ID is kept.

Top module: `tsa_adapter`

## Requirements
- R1: `core_tdi` is the logical inverse of the line value sampled on the rising `tckc` edge in slot 1, and it is stable while `core_tck` rises.
- R2: `core_tms` equals the line value sampled on the rising `tckc` edge in slot 2, and it is stable while `core_tck` rises.
- R3: Each frame gives exactly one `core_tck` pulse. It rises on the falling `tckc` edge that ends slot 2 and falls on the falling `tckc` edge that ends slot 3. `core_tck` is low during slots 1 and 2.
- R4: `core_tdo` is captured on each falling edge of `core_tck`. The captured bit is what the adapter drives in slot 3 of the next frame. After reset the captured bit is 1.
- R5: `tmsc_oe` is high only from the falling `tckc` edge that ends slot 2 to the falling edge that ends slot 3, and only when the node is selected. At all other times it is low.
- R6: The node is selected when `sel_vld` is 1 and `sel_id` equals the held ID. The held ID takes `cid_wr_data` on a rising `tckc` edge with `cid_wr_en` high. After reset the held ID is the parameter `RESET_CID`.
- R7: While `rst_n` is low (sampled on `tckc` edges): the slot counter returns to slot 1, `tmsc_oe` is 0, `core_tck` is 0 and `core_tms` is 1.
- R8: While `esc_hold` is 1: the slot counter returns to slot 1, `tmsc_oe` and `core_tck` are 0, and `core_tms` is 1. The held controller ID is not changed.
- R9: Slots cycle 1, 2, 3, 1, and so on, one per `tckc` cycle. The first rising `tckc` edge after reset or hold is released samples slot 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tckc | input | 1 | Host-driven line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| esc_hold | input | 1 | Realign request from an external escape detector |
| cid_wr_en | input | 1 | Load strobe for the held controller ID |
| cid_wr_data | input | CID_W | Controller ID value to load |
| sel_vld | input | 1 | A node selection is active |
| sel_id | input | CID_W | Controller ID currently selected |
| tmsc_in | input | 1 | Value seen on the shared data line |
| tmsc_out | output | 1 | Value to drive onto the data line |
| tmsc_oe | output | 1 | Output enable for the data-line pad |
| core_tck | output | 1 | Recovered core clock |
| core_tms | output | 1 | Recovered mode select |
| core_tdi | output | 1 | Recovered data in (already re-inverted) |
| core_tdo | input | 1 | Data out from the legacy core |

## Verification
The bench builds the adapter with `CID_W` = 4, `RESET_CID` = 3 and the binary slot counter. A 4-bit ID lets the bench pick an ID that does not match, so it can show that the line stays released. A non-zero reset ID is used because it can be told apart from a cleared register. The bench drives an 8-bit shift-register core from the recovered signals. This runs mode-select patterns with and without shifting, a mid-frame realign, and a mid-run reset. The known preload and the shifted-in data then show up, one frame late, on the returned bits.

// File: rtl/tsa_pkg.sv
// Shared types for the two-wire scan-format adapter.
// Assumes a frame of exactly three line slots per core clock.
package tsa_pkg;
    typedef enum logic [1:0] {
        SLOT_NTDI = 2'd0,
        SLOT_TMS  = 2'd1,
        SLOT_TDO  = 2'd2
    } slot_e;

    localparam int unsigned SLOTS_PER_FRAME = 3;
endpackage

// File: rtl/tsa_slot_ctr.sv
// Slot counter: tracks which of the three frame slots the line is in.
// It advances on each rising tckc edge. Reset and escape hold both return it to slot 1.
// ONEHOT selects a ring encoding instead of a binary count.
module tsa_slot_ctr
    import tsa_pkg::*;
#(
    parameter bit ONEHOT = 1'b0
) (
    input  logic  tckc,
    input  logic  rst_n,
    input  logic  esc_hold,
    output slot_e slot
);
    generate
        if (ONEHOT) begin : g_ring
            logic [SLOTS_PER_FRAME-1:0] ring;

            // Rotate a single hot bit through the three slot positions.
            always_ff @(posedge tckc) begin
                if (!rst_n || esc_hold)
                    ring <= {{(SLOTS_PER_FRAME-1){1'b0}}, 1'b1};
                else
                    ring <= {ring[SLOTS_PER_FRAME-2:0], ring[SLOTS_PER_FRAME-1]};
            end

            // Map the hot bit position onto the slot type.
            always_comb begin
                if (ring[2])      slot = SLOT_TDO;
                else if (ring[1]) slot = SLOT_TMS;
                else              slot = SLOT_NTDI;
            end
        end else begin : g_bin
            slot_e cnt;

            // Step the binary slot count 1 -> 2 -> 3 -> 1.
            always_ff @(posedge tckc) begin
                if (!rst_n || esc_hold)
                    cnt <= SLOT_NTDI;
                else begin
                    case (cnt)
                        SLOT_NTDI: cnt <= SLOT_TMS;
                        SLOT_TMS:  cnt <= SLOT_TDO;
                        default:   cnt <= SLOT_NTDI;
                    endcase
                end
            end

            assign slot = cnt;
        end
    endgenerate

    AST_SLOT_AFTER_NTDI: assert property (@(posedge tckc) disable iff (!rst_n || esc_hold)
        (slot == SLOT_NTDI) |=> (slot == SLOT_TMS)); // R9
    AST_SLOT_AFTER_TDO: assert property (@(posedge tckc) disable iff (!rst_n || esc_hold)
        (slot == SLOT_TDO) |=> (slot == SLOT_NTDI)); // R9
    AST_HOLD_REALIGNS: assert property (@(posedge tckc) disable iff (!rst_n)
        esc_hold |=> (slot == SLOT_NTDI)); // R8
endmodule

// File: rtl/tsa_rx_demux.sv
// Receive demultiplexer: on rising tckc it latches the slot-1 bit (re-inverted) as core TDI
// and the slot-2 bit as core TMS. Assumes the host changes the line only on falling tckc.
module tsa_rx_demux
    import tsa_pkg::*;
(
    input  logic  tckc,
    input  logic  rst_n,
    input  logic  esc_hold,
    input  slot_e slot,
    input  logic  tmsc_in,
    output logic  core_tdi,
    output logic  core_tms
);
    logic tdi_q;
    logic tms_q;

    // Capture the data-in bit from slot 1, undoing the line inversion.
    always_ff @(posedge tckc) begin
        if (!rst_n)
            tdi_q <= 1'b0;
        else if (!esc_hold && slot == SLOT_NTDI)
            tdi_q <= ~tmsc_in;
    end

    // Capture the mode-select bit from slot 2; park it at 1 in reset or hold.
    always_ff @(posedge tckc) begin
        if (!rst_n || esc_hold)
            tms_q <= 1'b1;
        else if (slot == SLOT_TMS)
            tms_q <= tmsc_in;
    end

    assign core_tdi = tdi_q;
    assign core_tms = tms_q;

    AST_TMS_PARK_RESET: assert property (@(posedge tckc)
        !rst_n |=> core_tms); // R7
    AST_TMS_PARK_HOLD: assert property (@(posedge tckc) disable iff (!rst_n)
        esc_hold |=> core_tms); // R8
    AST_TDI_TRACKS_LINE: assert property (@(posedge tckc) disable iff (!rst_n || esc_hold)
        (slot == SLOT_NTDI) |=> (core_tdi == !$past(tmsc_in))); // R1
endmodule

// File: rtl/tsa_cid_sel.sv
// Controller-ID holder and match: keeps the host-assigned ID and flags when the
// current selection names it. Escape hold does not touch the held ID.
module tsa_cid_sel #(
    parameter int unsigned         CID_W     = 4,
    parameter logic [CID_W-1:0]    RESET_CID = '0
) (
    input  logic             tckc,
    input  logic             rst_n,
    input  logic             cid_wr_en,
    input  logic [CID_W-1:0] cid_wr_data,
    input  logic             sel_vld,
    input  logic [CID_W-1:0] sel_id,
    output logic             selected
);
    logic [CID_W-1:0] cid_q;

    // Load the held ID when the assignment strobe is present.
    always_ff @(posedge tckc) begin
        if (!rst_n)
            cid_q <= RESET_CID;
        else if (cid_wr_en)
            cid_q <= cid_wr_data;
    end

    // Selected when a selection is active and it names this node.
    assign selected = sel_vld && (sel_id == cid_q);

    AST_CID_LOAD: assert property (@(posedge tckc) disable iff (!rst_n)
        cid_wr_en |=> (cid_q == $past(cid_wr_data))); // R6
endmodule

// File: rtl/tsa_tx_gen.sv
// Falling-edge side: makes the core clock pulse and the line driver enable from the slot
// counter, and captures core TDO on the falling core clock. Assumes the core updates TDO
// only on its rising clock, so the value is steady at the capture edge.
module tsa_tx_gen
    import tsa_pkg::*;
(
    input  logic  tckc,
    input  logic  rst_n,
    input  logic  esc_hold,
    input  slot_e slot,
    input  logic  selected,
    input  logic  core_tdo,
    output logic  core_tck,
    output logic  tmsc_out,
    output logic  tmsc_oe
);
    logic run;
    logic tck_q;
    logic oe_q;
    logic tdo_q;

    assign run = rst_n && !esc_hold;

    // Raise the core clock for exactly the third slot of each frame.
    always_ff @(negedge tckc) begin
        if (!run)
            tck_q <= 1'b0;
        else
            tck_q <= (slot == SLOT_TDO);
    end

    // Enable the line driver for the third slot, and only for the selected node.
    always_ff @(negedge tckc) begin
        if (!run)
            oe_q <= 1'b0;
        else
            oe_q <= (slot == SLOT_TDO) && selected;
    end

    // Capture core TDO on the edge where the core clock falls.
    always_ff @(negedge tckc) begin
        if (!rst_n)
            tdo_q <= 1'b1;
        else if (tck_q)
            tdo_q <= core_tdo;
    end

    assign core_tck = tck_q;
    assign tmsc_out = tdo_q;
    assign tmsc_oe  = oe_q;

    AST_TCK_SINGLE_SLOT: assert property (@(negedge tckc) disable iff (!rst_n)
        tck_q |=> !tck_q); // R3
    AST_OE_IN_TDO_SLOT: assert property (@(posedge tckc) disable iff (!rst_n)
        oe_q |-> (slot == SLOT_TDO)); // R5
    AST_QUIET_IN_RESET: assert property (@(negedge tckc)
        !rst_n |=> (!tck_q && !oe_q)); // R7
    AST_QUIET_IN_HOLD: assert property (@(negedge tckc) disable iff (!rst_n)
        esc_hold |=> (!tck_q && !oe_q)); // R8
endmodule

// File: rtl/tsa_adapter.sv
// Top of the two-wire scan-format adapter. The shared data line is split into an input,
// an output value and an output enable for an external tristate pad. All state is on the
// tckc domain: rising edges sample the host, falling edges drive the core clock and line.
module tsa_adapter
    import tsa_pkg::*;
#(
    parameter int unsigned      CID_W        = 4,
    parameter logic [CID_W-1:0] RESET_CID    = 4'h3,
    parameter bit               SLOT_ONEHOT  = 1'b0
) (
    input  logic             tckc,
    input  logic             rst_n,
    input  logic             esc_hold,
    input  logic             cid_wr_en,
    input  logic [CID_W-1:0] cid_wr_data,
    input  logic             sel_vld,
    input  logic [CID_W-1:0] sel_id,
    input  logic             tmsc_in,
    output logic             tmsc_out,
    output logic             tmsc_oe,
    output logic             core_tck,
    output logic             core_tms,
    output logic             core_tdi,
    input  logic             core_tdo
);
    slot_e slot;
    logic  selected;

    tsa_slot_ctr #(
        .ONEHOT (SLOT_ONEHOT)
    ) i_slot_ctr (
        .tckc     (tckc),
        .rst_n    (rst_n),
        .esc_hold (esc_hold),
        .slot     (slot)
    );

    tsa_rx_demux i_rx_demux (
        .tckc     (tckc),
        .rst_n    (rst_n),
        .esc_hold (esc_hold),
        .slot     (slot),
        .tmsc_in  (tmsc_in),
        .core_tdi (core_tdi),
        .core_tms (core_tms)
    );

    tsa_cid_sel #(
        .CID_W     (CID_W),
        .RESET_CID (RESET_CID)
    ) i_cid_sel (
        .tckc        (tckc),
        .rst_n       (rst_n),
        .cid_wr_en   (cid_wr_en),
        .cid_wr_data (cid_wr_data),
        .sel_vld     (sel_vld),
        .sel_id      (sel_id),
        .selected    (selected)
    );

    tsa_tx_gen i_tx_gen (
        .tckc     (tckc),
        .rst_n    (rst_n),
        .esc_hold (esc_hold),
        .slot     (slot),
        .selected (selected),
        .core_tdo (core_tdo),
        .core_tck (core_tck),
        .tmsc_out (tmsc_out),
        .tmsc_oe  (tmsc_oe)
    );
endmodule

// File: tb/test_tsa_adapter.sv
`timescale 1ns/1ps
module test_tsa_adapter;
    localparam int unsigned      CID_W   = 4;
    localparam logic [CID_W-1:0] RST_CID = 4'h3;

    logic             tckc = 1'b0;
    logic             rst_n = 1'b0;
    logic             esc_hold = 1'b0;
    logic             cid_wr_en = 1'b0;
    logic [CID_W-1:0] cid_wr_data = '0;
    logic             sel_vld = 1'b0;
    logic [CID_W-1:0] sel_id = '0;
    logic             tmsc_out, tmsc_oe, core_tck, core_tms, core_tdi, core_tdo;
    logic             host_oe = 1'b0;
    logic             host_val = 1'b1;
    wire              bus = tmsc_oe ? tmsc_out : (host_oe ? host_val : 1'b1);

    // 200 MHz line clock
    always #2.5 tckc = ~tckc;

    tsa_adapter #(.CID_W(CID_W), .RESET_CID(RST_CID)) i_tsa_adapter (
        .tckc(tckc), .rst_n(rst_n), .esc_hold(esc_hold),
        .cid_wr_en(cid_wr_en), .cid_wr_data(cid_wr_data),
        .sel_vld(sel_vld), .sel_id(sel_id), .tmsc_in(bus),
        .tmsc_out(tmsc_out), .tmsc_oe(tmsc_oe), .core_tck(core_tck),
        .core_tms(core_tms), .core_tdi(core_tdi), .core_tdo(core_tdo)
    );

    // Simple legacy core: 8-bit shift register, shifts when TMS is 0.
    logic [7:0] core_sr = 8'hA5;
    logic       seen_tdi = 1'b0;
    logic       seen_tms = 1'b0;
    assign core_tdo = core_sr[0];
    always @(posedge core_tck) begin
        seen_tdi <= core_tdi;
        seen_tms <= core_tms;
        if (!core_tms) core_sr <= {core_tdi, core_sr[7:1]};
    end

    // Bench model of the core and of the returned bit
    logic [7:0] mdl = 8'hA5;
    logic       exp_ret = 1'b1;
    int         n_chk = 0;
    int         n_err = 0;
    int         contention = 0;

    always @(posedge tckc) if (host_oe && tmsc_oe) contention++;

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    // One three-slot frame; optional ID load during slot 1.
    task automatic frame(input logic tdi, input logic tms, input logic sel_exp,
                         input logic wr, input logic [CID_W-1:0] wr_val);
        @(negedge tckc); #0.5;
        host_oe = 1'b1; host_val = ~tdi; cid_wr_en = wr; cid_wr_data = wr_val;
        chk("R3 tck low in slot 1", core_tck, 1'b0);
        chk("R5 no drive in slot 1", tmsc_oe, 1'b0);
        @(posedge tckc); #0.5;
        chk("R1 tdi recovered", core_tdi, tdi);
        @(negedge tckc); #0.5;
        host_val = tms; cid_wr_en = 1'b0;
        chk("R3 tck low in slot 2", core_tck, 1'b0);
        chk("R5 no drive in slot 2", tmsc_oe, 1'b0);
        @(posedge tckc); #0.5;
        host_oe = 1'b0;
        chk("R2 tms recovered", core_tms, tms);
        @(negedge tckc); #0.5;
        chk("R3 tck high in slot 3", core_tck, 1'b1);
        chk("R5 drive follows selection", tmsc_oe, sel_exp);
        chk("R1 core saw tdi", seen_tdi, tdi);
        chk("R2 core saw tms", seen_tms, tms);
        @(posedge tckc); #0.5;
        chk("R4 returned bit", bus, sel_exp ? exp_ret : 1'b1);
        if (!tms) mdl = {tdi, mdl[7:1]};
        exp_ret = mdl[0];
    endtask

    task automatic t_reset();
        rst_n = 1'b0; host_oe = 1'b0; esc_hold = 1'b0;
        repeat (3) @(posedge tckc);
        #0.5;
        chk("R7 tck low in reset", core_tck, 1'b0);
        chk("R7 no drive in reset", tmsc_oe, 1'b0);
        chk("R7 tms parked high", core_tms, 1'b1);
        exp_ret = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic t_shift_selected();
        logic [7:0] pat = 8'b1100_1010;
        sel_vld = 1'b1; sel_id = RST_CID;
        for (int i = 0; i < 8; i++) frame(pat[i], 1'b0, 1'b1, 1'b0, '0);
        for (int i = 0; i < 4; i++) frame(1'b0, 1'b0, 1'b1, 1'b0, '0);
    endtask

    task automatic t_tms_mix();
        frame(1'b1, 1'b1, 1'b1, 1'b0, '0);
        frame(1'b0, 1'b1, 1'b1, 1'b0, '0);
        frame(1'b1, 1'b0, 1'b1, 1'b0, '0);
        frame(1'b0, 1'b1, 1'b1, 1'b0, '0);
        frame(1'b1, 1'b0, 1'b1, 1'b0, '0);
    endtask

    task automatic t_unselected();
        sel_id = 4'h9;
        frame(1'b0, 1'b0, 1'b0, 1'b0, '0);
        frame(1'b1, 1'b0, 1'b0, 1'b0, '0);
        sel_vld = 1'b0; sel_id = RST_CID;
        frame(1'b0, 1'b0, 1'b0, 1'b0, '0);
        frame(1'b1, 1'b0, 1'b0, 1'b0, '0);
    endtask

    task automatic t_cid_load();
        sel_vld = 1'b1; sel_id = 4'h9;
        frame(1'b0, 1'b0, 1'b1, 1'b1, 4'h9); // R6 new ID selects in same frame
        frame(1'b1, 1'b0, 1'b1, 1'b0, '0);
        sel_id = RST_CID;
        frame(1'b0, 1'b0, 1'b0, 1'b0, '0);   // R6 old ID no longer matches
        sel_id = 4'h9;
    endtask

    task automatic t_hold();
        @(negedge tckc); #0.5;
        host_oe = 1'b1; host_val = 1'b0;
        @(negedge tckc); #0.5;
        esc_hold = 1'b1; host_val = 1'b0;
        @(posedge tckc); #0.5;
        host_oe = 1'b0;
        chk("R8 tms parked high in hold", core_tms, 1'b1);
        @(negedge tckc); #0.5;
        chk("R8 no tck in hold", core_tck, 1'b0);
        chk("R8 no drive in hold", tmsc_oe, 1'b0);
        @(posedge tckc); #0.5;
        esc_hold = 1'b0;
        // R9 realigned frames; held ID 9 kept through hold (R8)
        frame(1'b1, 1'b0, 1'b1, 1'b0, '0);
        frame(1'b0, 1'b0, 1'b1, 1'b0, '0);
        frame(1'b1, 1'b1, 1'b1, 1'b0, '0);
    endtask

    task automatic t_reset_midrun();
        @(negedge tckc); #0.5;
        t_reset();
        sel_vld = 1'b1; sel_id = RST_CID;   // R6 reset ID back in force
        frame(1'b0, 1'b0, 1'b1, 1'b0, '0);  // R4 reset value returned first
        frame(1'b1, 1'b0, 1'b1, 1'b0, '0);
    endtask

    initial begin
        #1000000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_shift_selected();
        t_tms_mix();
        t_unselected();
        t_cid_load();
        t_hold();
        t_reset_midrun();
        chk("R5 no line contention", contention == 0, 1'b1);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule